// File: doc/BRIEF.md
# Configurable Mux-Register I/O Cell

This block is one I/O cell of a crosspoint-style switching fabric. A 4:1 multiplexer picks one of four routed fabric lines as the outgoing data. The selected line is always offered back to the fabric unregistered, so that neighbouring cells can chain it into wider multiplexers. Toward the pad, the cell drives a data word and an output enable. The received pad word is also returned to the fabric.

Three storage elements sit on the three paths: outgoing data, output enable and incoming pad data. Static configuration picks, for each element on its own, either a rising-edge flop or a latch that is transparent while the clock is high. The outgoing and incoming data paths can each skip their element and become purely combinational. The output-enable path always goes through its element.

An active-high asynchronous reset loads every element with a configured start value. The reset also acts as the only window in which the configuration inputs are taken in. Once reset is released, the captured configuration stays fixed until the next reset.

Top module: `muxRegCell`

## Requirements
- R1: `fabMuxOut` equals fabric line `sel` at all times, combinationally. Line k occupies bits `[k*W +: W]` of `fabIn`.
- R2: An element in flop mode (its `cfgLatch` bit is 0) takes its input on the rising clock edge and holds it at every other time.
- R3: An element in latch mode (its `cfgLatch` bit is 1) follows its input while `clk` is high and holds the last value while `clk` is low. The bits map as follows: bit 0 is the incoming-data element, bit 1 the outgoing-data element and bit 2 the output-enable element.
- R4: With `cfgOutBypass` = 1, `padData` follows `fabMuxOut` combinationally. With `cfgOutBypass` = 0, `padData` is the outgoing element's content.
- R5: With `cfgInBypass` = 1, `fabPadIn` follows `padIn` combinationally. With `cfgInBypass` = 0, `fabPadIn` is the incoming element's content.
- R6: `padOe` is `oeSrc` passed through the third element, with no bypass. `padOe` = 0 means the pad driver is released to high impedance. Incoming pad data is still captured while `padOe` is 0.
- R7: While `rst` is high, each element holds its start value, whatever `clk` and the data inputs do. The start values are `cfgInit` bit 0 (incoming, replicated over W), bit 1 (outgoing, replicated over W) and bit 2 (output enable).
- R8: The configuration inputs (`cfgLatch`, `cfgInBypass`, `cfgOutBypass`, `cfgInit`) are taken in only while `rst` is high. Changing them after release has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for flop mode; enable for latch mode |
| rst | input | 1 | Asynchronous set/reset, active high; also the configuration window |
| cfgLatch | input | 3 | Per-element mode, 1 = latch, 0 = flop |
| cfgInBypass | input | 1 | Incoming data path skips its element |
| cfgOutBypass | input | 1 | Outgoing data path skips its element |
| cfgInit | input | 3 | Start values loaded by reset |
| fabIn | input | NUM_LINES*W | Four routed fabric lines |
| sel | input | SEL_W | Line select |
| oeSrc | input | 1 | Output-enable source |
| padIn | input | W | Data received from the pad |
| padData | output | W | Data toward the pad driver |
| padOe | output | 1 | Pad driver enable; 0 = high impedance |
| fabMuxOut | output | W | Selected line toward the fabric, for cascading |
| fabPadIn | output | W | Received pad data toward the fabric |

## Verification
The temporal assertions compare outputs with the captured configuration, not with the configuration ports. They therefore rely on the configuration inputs being stable whenever `rst` goes high, and on `rst` changing only while `clk` is low. The flop-mode properties also rely on data inputs being settled at each rising edge.

The stimulus respects these limits. It changes `rst` and the configuration only shortly after a falling edge, and changes data inputs only shortly after an edge. It then deliberately inverts every configuration input after release, so that a cell which keeps listening to them diverges from the expected values.

// File: rtl/muxRegCell_pkg.sv
package muxRegCell_pkg;

  // Per-element index into the three-bit configuration fields
  localparam int ELEM_IN  = 0;
  localparam int ELEM_OUT = 1;
  localparam int ELEM_OE  = 2;

  // Configuration as captured during reset; drives the datapath
  typedef struct packed {
    logic [2:0] latchMode;
    logic       inBypass;
    logic       outBypass;
    logic [2:0] initVal;
  } cellCfg_t;

endpackage

// File: rtl/storeElem.sv
module storeElem #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         latchMode,
  input  logic [W-1:0] initVal,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] flopQ;
  logic [W-1:0] latchQ;

  // Edge-triggered variant; reset has priority and reloads on every edge while held
  always_ff @(posedge clk or posedge rst) begin
    if (rst) flopQ <= initVal;
    else     flopQ <= d;
  end

  // Level-sensitive variant; transparent while clk high
  always_latch begin
    if (rst)      latchQ <= initVal;
    else if (clk) latchQ <= d;
  end

  assign q = latchMode ? latchQ : flopQ;

endmodule

// File: rtl/cellCtrl.sv
module cellCtrl
  import muxRegCell_pkg::*;
(
  input  logic     rst,
  input  logic [2:0] cfgLatch,
  input  logic     cfgInBypass,
  input  logic     cfgOutBypass,
  input  logic [2:0] cfgInit,
  output cellCfg_t cfgOut
);

  cellCfg_t cfgQ;

  // Configuration window: open only while reset is asserted
  always_latch begin
    if (rst) begin
      cfgQ.latchMode <= cfgLatch;
      cfgQ.inBypass  <= cfgInBypass;
      cfgQ.outBypass <= cfgOutBypass;
      cfgQ.initVal   <= cfgInit;
    end
  end

  assign cfgOut = cfgQ;

endmodule

// File: rtl/cellDatapath.sv
module cellDatapath
  import muxRegCell_pkg::*;
#(
  parameter int W         = 2,
  parameter int NUM_LINES = 4,
  localparam int SEL_W    = $clog2(NUM_LINES)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  cellCfg_t               cfg,
  input  logic [NUM_LINES*W-1:0] fabIn,
  input  logic [SEL_W-1:0]       sel,
  input  logic                   oeSrc,
  input  logic [W-1:0]           padIn,
  output logic [W-1:0]           padData,
  output logic                   padOe,
  output logic [W-1:0]           fabMuxOut,
  output logic [W-1:0]           fabPadIn
);

  logic [W-1:0] muxSel;
  logic [W-1:0] outQ;
  logic [W-1:0] inQ;

  // Line select
  always_comb begin
    muxSel = '0;
    for (int k = 0; k < NUM_LINES; k++) begin
      if (sel == SEL_W'(k)) muxSel = fabIn[k*W +: W];
    end
  end

  storeElem #(.W(W)) u_outElem (
    .clk       (clk),
    .rst       (rst),
    .latchMode (cfg.latchMode[ELEM_OUT]),
    .initVal   ({W{cfg.initVal[ELEM_OUT]}}),
    .d         (muxSel),
    .q         (outQ)
  );

  storeElem #(.W(W)) u_inElem (
    .clk       (clk),
    .rst       (rst),
    .latchMode (cfg.latchMode[ELEM_IN]),
    .initVal   ({W{cfg.initVal[ELEM_IN]}}),
    .d         (padIn),
    .q         (inQ)
  );

  storeElem #(.W(1)) u_oeElem (
    .clk       (clk),
    .rst       (rst),
    .latchMode (cfg.latchMode[ELEM_OE]),
    .initVal   (cfg.initVal[ELEM_OE]),
    .d         (oeSrc),
    .q         (padOe)
  );

  assign fabMuxOut = muxSel;
  assign padData   = cfg.outBypass ? muxSel : outQ;
  assign fabPadIn  = cfg.inBypass  ? padIn  : inQ;

endmodule

// File: rtl/muxRegCell.sv
module muxRegCell
  import muxRegCell_pkg::*;
#(
  parameter int W         = 2,
  parameter int NUM_LINES = 4,
  localparam int SEL_W    = $clog2(NUM_LINES)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [2:0]             cfgLatch,
  input  logic                   cfgInBypass,
  input  logic                   cfgOutBypass,
  input  logic [2:0]             cfgInit,
  input  logic [NUM_LINES*W-1:0] fabIn,
  input  logic [SEL_W-1:0]       sel,
  input  logic                   oeSrc,
  input  logic [W-1:0]           padIn,
  output logic [W-1:0]           padData,
  output logic                   padOe,
  output logic [W-1:0]           fabMuxOut,
  output logic [W-1:0]           fabPadIn
);

  cellCfg_t cellCfg;

  cellCtrl u_ctrl (
    .rst          (rst),
    .cfgLatch     (cfgLatch),
    .cfgInBypass  (cfgInBypass),
    .cfgOutBypass (cfgOutBypass),
    .cfgInit      (cfgInit),
    .cfgOut       (cellCfg)
  );

  cellDatapath #(.W(W), .NUM_LINES(NUM_LINES)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .cfg       (cellCfg),
    .fabIn     (fabIn),
    .sel       (sel),
    .oeSrc     (oeSrc),
    .padIn     (padIn),
    .padData   (padData),
    .padOe     (padOe),
    .fabMuxOut (fabMuxOut),
    .fabPadIn  (fabPadIn)
  );

endmodule

// File: rtl/muxRegCellChk.sv
module muxRegCellChk
  import muxRegCell_pkg::*;
#(
  parameter int W = 2
) (
  input logic         clk,
  input logic         rst,
  input cellCfg_t     cfg,
  input logic [W-1:0] fabMuxOut,
  input logic [W-1:0] padData,
  input logic         padOe,
  input logic [W-1:0] fabPadIn,
  input logic [W-1:0] padIn,
  input logic         oeSrc
);

  // Set once a full edge has passed since reset release
  logic armed;
  always_ff @(posedge clk or posedge rst) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  AST_FLOP_OUT: assert property (@(posedge clk) disable iff (rst)
    (armed && !cfg.outBypass && !cfg.latchMode[ELEM_OUT]) |-> padData == $past(fabMuxOut)); // R2

  AST_FLOP_IN: assert property (@(posedge clk) disable iff (rst)
    (armed && !cfg.inBypass && !cfg.latchMode[ELEM_IN]) |-> fabPadIn == $past(padIn)); // R2

  AST_FLOP_OE: assert property (@(posedge clk) disable iff (rst)
    (armed && !cfg.latchMode[ELEM_OE]) |-> padOe == $past(oeSrc)); // R6

  AST_LATCH_OUT: assert property (@(negedge clk) disable iff (rst)
    (!cfg.outBypass && cfg.latchMode[ELEM_OUT]) |-> padData == fabMuxOut); // R3

  AST_LATCH_IN: assert property (@(negedge clk) disable iff (rst)
    (!cfg.inBypass && cfg.latchMode[ELEM_IN]) |-> fabPadIn == padIn); // R3

  AST_BYPASS_OUT: assert property (@(posedge clk) disable iff (rst)
    cfg.outBypass |-> padData == fabMuxOut); // R4

  AST_BYPASS_IN: assert property (@(posedge clk) disable iff (rst)
    cfg.inBypass |-> fabPadIn == padIn); // R5

  always @(negedge clk) begin
    if (rst) begin
      AST_RESET_FORCE: assert (padOe == cfg.initVal[ELEM_OE] &&
        (cfg.outBypass || padData == {W{cfg.initVal[ELEM_OUT]}}) &&
        (cfg.inBypass  || fabPadIn == {W{cfg.initVal[ELEM_IN]}})); // R7
    end
  end

endmodule

bind muxRegCell muxRegCellChk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg       (cellCfg),
  .fabMuxOut (fabMuxOut),
  .padData   (padData),
  .padOe     (padOe),
  .fabPadIn  (fabPadIn),
  .padIn     (padIn),
  .oeSrc     (oeSrc)
);

// File: tb/muxRegCell_bench.sv
module muxRegCell_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 2;
  localparam int LINES      = 4;
  localparam int SW         = 2;

  logic             clk;
  logic             rst;
  logic [2:0]       cfgLatch;
  logic             cfgInBypass;
  logic             cfgOutBypass;
  logic [2:0]       cfgInit;
  logic [LINES*W-1:0] fabIn;
  logic [SW-1:0]    sel;
  logic             oeSrc;
  logic [W-1:0]     padIn;
  logic [W-1:0]     padData;
  logic             padOe;
  logic [W-1:0]     fabMuxOut;
  logic [W-1:0]     fabPadIn;

  muxRegCell #(.W(W), .NUM_LINES(LINES)) u_muxRegCell (
    .clk          (clk),
    .rst          (rst),
    .cfgLatch     (cfgLatch),
    .cfgInBypass  (cfgInBypass),
    .cfgOutBypass (cfgOutBypass),
    .cfgInit      (cfgInit),
    .fabIn        (fabIn),
    .sel          (sel),
    .oeSrc        (oeSrc),
    .padIn        (padIn),
    .padData      (padData),
    .padOe        (padOe),
    .fabMuxOut    (fabMuxOut),
    .fabPadIn     (fabPadIn)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Configuration under test
  bit [2:0] latchM;
  bit       inByp, outByp;
  bit [2:0] initV;
  bit       inReset;

  function automatic logic [W-1:0] lineOf(logic [LINES*W-1:0] f, int s);
    logic [LINES*W-1:0] t;
    t = f >> (s * W);
    return t[W-1:0];
  endfunction

  task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h (cfg latch=%b inByp=%b outByp=%b init=%b)",
               req, what, act, exp, latchM, inByp, outByp, initV);
    end
  endtask

  function automatic string modeTag(bit byp, bit lat, string bypTag);
    if (byp)     return bypTag;
    if (inReset) return "R7";
    if (lat)     return "R3";
    return "R2";
  endfunction

  // Compare all outputs; eIn/eOut/eOe are the expected element contents
  task automatic checkAll(logic [W-1:0] eIn, logic [W-1:0] eOut, logic eOe);
    string sfx;
    string oeTag;
    sfx   = inReset ? "" : "/R8";
    oeTag = inReset ? "R7" : (latchM[2] ? "R6/R3" : "R6/R2");
    chk("R1", "fabMuxOut", fabMuxOut, lineOf(fabIn, int'(sel)));
    chk({modeTag(outByp, latchM[1], "R4"), sfx}, "padData", padData,
        outByp ? lineOf(fabIn, int'(sel)) : eOut);
    chk({modeTag(inByp, latchM[0], "R5"), sfx}, "fabPadIn", fabPadIn,
        inByp ? padIn : eIn);
    chk({oeTag, sfx}, "padOe", W'(padOe), W'(eOe));
  endtask

  task automatic driveIn(logic [LINES*W-1:0] f, logic [SW-1:0] s, logic [W-1:0] p, logic o);
    fabIn = f;
    sel   = s;
    padIn = p;
    oeSrc = o;
  endtask

  initial begin
    logic [W-1:0] heldIn, heldOut, rIn, rOut;
    logic         heldOe, rOe;
    rst = 1'b1;
    cfgLatch = '0; cfgInBypass = 1'b0; cfgOutBypass = 1'b0; cfgInit = '0;
    driveIn('0, '0, '0, 1'b0);

    for (int c = 0; c < 256; c++) begin
      latchM  = c[2:0];
      inByp   = c[3];
      outByp  = c[4];
      initV   = c[7:5];
      rIn     = {W{initV[0]}};
      rOut    = {W{initV[1]}};
      rOe     = initV[2];

      // Reset phase: configuration taken in, start values forced (R7)
      @(negedge clk); #1;
      inReset      = 1'b1;
      rst          = 1'b1;
      cfgLatch     = latchM;
      cfgInBypass  = inByp;
      cfgOutBypass = outByp;
      cfgInit      = initV;
      driveIn(8'((c * 91) + 13), SW'(c), W'(c + 1), 1'b1);
      @(posedge clk); #1;
      checkAll(rIn, rOut, rOe);
      driveIn(8'((c * 17) + 200), SW'(c + 2), W'(c + 2), ~rOe);
      #1;
      checkAll(rIn, rOut, rOe);
      @(negedge clk); #1;
      checkAll(rIn, rOut, rOe);

      // Release and scramble the configuration ports (R8)
      rst          = 1'b0;
      inReset      = 1'b0;
      cfgLatch     = ~latchM;
      cfgInBypass  = ~inByp;
      cfgOutBypass = ~outByp;
      cfgInit      = ~initV;
      heldIn  = rIn;
      heldOut = rOut;
      heldOe  = rOe;

      for (int s = 0; s < 4; s++) begin
        logic [LINES*W-1:0] fa;
        logic [SW-1:0]      sa;
        logic [W-1:0]       pa, aOut, bOut;
        logic               oa;
        fa = 8'((c * 53) + (s * 29) + 7);
        sa = SW'(c + s);
        pa = W'(c + s * 3);
        oa = 1'(((c + s) / 2) % 2);
        aOut = lineOf(fa, int'(sa));
        bOut = lineOf(~fa, int'(sa));

        // Clock low: every element holds (R2, R3)
        checkAll(heldIn, heldOut, heldOe);
        driveIn(fa, sa, pa, oa);
        #1;
        checkAll(heldIn, heldOut, heldOe);

        // Just after the rising edge both modes show the new value
        @(posedge clk); #1;
        checkAll(pa, aOut, oa);

        // Change inputs while clock high: latch follows, flop holds
        driveIn(~fa, sa, ~pa, ~oa);
        #1;
        heldIn  = latchM[0] ? ~pa  : pa;
        heldOut = latchM[1] ? bOut : aOut;
        heldOe  = latchM[2] ? ~oa  : oa;
        checkAll(heldIn, heldOut, heldOe);

        @(negedge clk); #1;
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  // Watchdog
  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule